// File: doc/BRIEF.md
# Store Permission Guard

This block decides whether a store to a logical address may proceed under three protection mechanisms that do not depend on storage keys. The first is the read-only attribute of an address space reached in access-register mode. The second is page protection taken from the segment-table and page-table entries of a translated access. The third is the low-address fence, which guards the first 512 bytes of each of the two lowest 4 KiB pages.

The requester presents one access per cycle with `req_valid`. It supplies the access type, the effective address, the translation and mode flags, the table-entry protection bits and the exemption flags. One clock later the block returns a response strobe, a protection-exception flag and a 2-bit cause. Every exception it raises also carries a suppress indication, so the instruction is nullified rather than terminated. Table walks, storage-key checks and ranking against other program exceptions belong to neighbouring logic.

Top module: `store_guard`

## Requirements
- R1: After reset and until the first request, `resp_valid`, `prot_exc`, `exc_cause` and `suppress` are all 0.
- R2: The response appears on the first rising edge after the request is sampled. `resp_valid` is 1 exactly one cycle after `req_valid` is 1. A cycle without a request gives `prot_exc`=0 and `exc_cause`=00 in the following cycle.
- R3: A fetch (`req_store`=0) never raises an exception, whatever the other inputs are.
- R4: A store in access-register mode (`ar_mode`=1) with `ale_fetch_only`=1 raises an exception with cause 11. Outside access-register mode, `ale_fetch_only` has no effect.
- R5: A translated store (`translated`=1) raises an exception with cause 10 when `seg_prot` OR `pte_prot` is 1. When `translated`=0, both bits are ignored.
- R6: With `lap_enable`=1, a store raises an exception with cause 01 when the effective address is in 0..511 or 4096..4607. The addresses 512, 4095, 4608 and all higher addresses pass.
- R7: With `lap_enable`=0, the low-address fence never fires.
- R8: A store flagged as part of an interruption sequence (`intr_seq`=1) is exempt from the low-address fence.
- R9: A store whose address-space element is unavailable (`asce_unavail`=1) is exempt from the low-address fence.
- R10: When several causes apply, the reported cause follows the priority access-list (11), then page (10), then low-address (01).
- R11: `suppress` equals `prot_exc` in every cycle. The cause is nonzero exactly when `prot_exc`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access presented this cycle |
| req_store | input | 1 | 1 = store, 0 = fetch |
| eff_addr | input | ADDR_W | Effective address |
| ar_mode | input | 1 | Access-register addressing mode |
| translated | input | 1 | Access goes through address translation |
| seg_prot | input | 1 | Segment-entry protection bit |
| pte_prot | input | 1 | Page-entry protection bit |
| ale_fetch_only | input | 1 | Address space is read-only |
| lap_enable | input | 1 | Low-address fence enabled |
| intr_seq | input | 1 | Access belongs to an interruption sequence |
| asce_unavail | input | 1 | Address-space element unavailable |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| prot_exc | output | 1 | Protection exception |
| exc_cause | output | 2 | 00 none, 01 low-address, 10 page, 11 access-list |
| suppress | output | 1 | Exception must suppress the instruction |

## Verification
Every result is due on the first rising edge after the request is sampled, because the decision passes through a single register stage. The bench changes inputs only on falling edges. It waits for the next rising edge and reads the outputs one nanosecond after it, so each check sees the response to exactly one request. Idle cycles are checked in the same way, one edge after the request is withdrawn.

// File: rtl/store_guard.sv
module store_guard #(
  parameter int ADDR_W     = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int LOW_BYTES  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              ar_mode,
  input  logic              translated,
  input  logic              seg_prot,
  input  logic              pte_prot,
  input  logic              ale_fetch_only,
  input  logic              lap_enable,
  input  logic              intr_seq,
  input  logic              asce_unavail,
  output logic              resp_valid,
  output logic              prot_exc,
  output logic [1:0]        exc_cause,
  output logic              suppress
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int LOW_LSB  = $clog2(LOW_BYTES);
  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_LOW  = 2'b01;
  localparam logic [1:0] CAUSE_PAGE = 2'b10;
  localparam logic [1:0] CAUSE_ALE  = 2'b11;

  // Address lies in the first LOW_BYTES of page 0 or page 1
  wire in_band   = (eff_addr[PAGE_LSB-1:LOW_LSB] == '0);
  wire low_pages = (eff_addr[ADDR_W-1:PAGE_LSB+1] == '0);
  wire in_fence  = in_band & low_pages;

  wire is_store  = req_valid & req_store;
  wire ale_hit   = is_store & ar_mode & ale_fetch_only;
  wire page_hit  = is_store & translated & (seg_prot | pte_prot);
  wire low_hit   = is_store & lap_enable & in_fence & ~intr_seq & ~asce_unavail;

  logic [1:0] cause_d;
  always_comb begin
    if (ale_hit)       cause_d = CAUSE_ALE;
    else if (page_hit) cause_d = CAUSE_PAGE;
    else if (low_hit)  cause_d = CAUSE_LOW;
    else               cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      exc_cause  <= CAUSE_NONE;
    end else begin
      resp_valid <= req_valid;
      exc_cause  <= cause_d;
    end
  end

  assign prot_exc = (exc_cause != CAUSE_NONE);
  assign suppress = prot_exc;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!resp_valid && !prot_exc));
  assert_fetch_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |=> !prot_exc);
  assert_ale_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && ar_mode && ale_fetch_only) |=> (exc_cause == 2'b11));
  assert_real_no_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !translated) |=> (exc_cause != 2'b10));
  assert_lap_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lap_enable) |=> (exc_cause != 2'b01));
  assert_intr_exempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && intr_seq) |=> (exc_cause != 2'b01));
  assert_asce_exempt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && asce_unavail) |=> (exc_cause != 2'b01));
  assert_suppress_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prot_exc |-> (suppress && resp_valid));
endmodule

// File: tb/store_guard_tb.sv
module store_guard_tb_top;
  localparam int AW = 64;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, ar_mode = 0, translated = 0;
  logic seg_prot = 0, pte_prot = 0, ale_fetch_only = 0, lap_enable = 0;
  logic intr_seq = 0, asce_unavail = 0;
  logic [AW-1:0] eff_addr = '0;
  logic resp_valid, prot_exc, suppress;
  logic [1:0] exc_cause;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  store_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .eff_addr(eff_addr), .ar_mode(ar_mode), .translated(translated),
    .seg_prot(seg_prot), .pte_prot(pte_prot), .ale_fetch_only(ale_fetch_only),
    .lap_enable(lap_enable), .intr_seq(intr_seq), .asce_unavail(asce_unavail),
    .resp_valid(resp_valid), .prot_exc(prot_exc), .exc_cause(exc_cause),
    .suppress(suppress));

  task automatic check(input string req, input logic ev, input logic [1:0] ec);
    checks++;
    if (resp_valid !== ev || exc_cause !== ec || prot_exc !== (ec != 2'b00) ||
        suppress !== (ec != 2'b00)) begin
      errors++;
      $display("FAIL %s: got valid=%b exc=%b cause=%b sup=%b, expected valid=%b cause=%b",
               req, resp_valid, prot_exc, exc_cause, suppress, ev, ec);
    end
  endtask

  task automatic clear_in();
    req_valid = 0; req_store = 0; ar_mode = 0; translated = 0; seg_prot = 0;
    pte_prot = 0; ale_fetch_only = 0; lap_enable = 0; intr_seq = 0;
    asce_unavail = 0; eff_addr = '0;
  endtask

  // Fields: st, ar, tr, sp, pp, fo, lap, is, au
  task automatic access(input logic st, input logic [AW-1:0] a, input logic ar,
                        input logic tr, input logic sp, input logic pp, input logic fo,
                        input logic lap, input logic is, input logic au,
                        input string req, input logic [1:0] ec);
    @(negedge clk);
    clear_in();
    req_valid = 1; req_store = st; eff_addr = a; ar_mode = ar; translated = tr;
    seg_prot = sp; pte_prot = pp; ale_fetch_only = fo; lap_enable = lap;
    intr_seq = is; asce_unavail = au;
    @(posedge clk); #1;
    check(req, 1'b1, ec);
  endtask

  task automatic t_reset_R1();
    #1 check("R1 reset", 1'b0, 2'b00);
  endtask

  task automatic t_idle_R2();
    @(negedge clk); clear_in(); ar_mode = 1; ale_fetch_only = 1; req_store = 1;
    @(posedge clk); #1;
    check("R2 idle", 1'b0, 2'b00);
  endtask

  task automatic t_fetch_R3();
    access(0, 64'd100, 1, 1, 1, 1, 1, 1, 0, 0, "R3 fetch all set", 2'b00);
  endtask

  task automatic t_ale_R4();
    access(1, 64'h10000, 1, 0, 0, 0, 1, 0, 0, 0, "R4 fetch-only", 2'b11);
    access(1, 64'h10000, 0, 0, 0, 0, 1, 0, 0, 0, "R4 not AR mode", 2'b00);
    access(1, 64'h10000, 1, 0, 0, 0, 0, 0, 0, 0, "R4 writable", 2'b00);
  endtask

  task automatic t_page_R5();
    access(1, 64'h20000, 0, 1, 1, 0, 0, 0, 0, 0, "R5 seg bit", 2'b10);
    access(1, 64'h20000, 0, 1, 0, 1, 0, 0, 0, 0, "R5 pte bit", 2'b10);
    access(1, 64'h20000, 0, 1, 0, 0, 0, 0, 0, 0, "R5 clear", 2'b00);
    access(1, 64'h20000, 0, 0, 1, 1, 0, 0, 0, 0, "R5 real ignores", 2'b00);
  endtask

  task automatic t_low_R6();
    access(1, 64'd0,    0, 0, 0, 0, 0, 1, 0, 0, "R6 addr 0", 2'b01);
    access(1, 64'd511,  0, 0, 0, 0, 0, 1, 0, 0, "R6 addr 511", 2'b01);
    access(1, 64'd512,  0, 0, 0, 0, 0, 1, 0, 0, "R6 addr 512", 2'b00);
    access(1, 64'd4095, 0, 0, 0, 0, 0, 1, 0, 0, "R6 addr 4095", 2'b00);
    access(1, 64'd4096, 0, 0, 0, 0, 0, 1, 0, 0, "R6 addr 4096", 2'b01);
    access(1, 64'd4607, 0, 0, 0, 0, 0, 1, 0, 0, "R6 addr 4607", 2'b01);
    access(1, 64'd4608, 0, 0, 0, 0, 0, 1, 0, 0, "R6 addr 4608", 2'b00);
    access(1, 64'd8192, 0, 0, 0, 0, 0, 1, 0, 0, "R6 addr 8192", 2'b00);
    access(1, 64'h8000_0000_0000_0100, 0, 0, 0, 0, 0, 1, 0, 0, "R6 high bit", 2'b00);
  endtask

  task automatic t_lap_off_R7();
    access(1, 64'd16, 0, 0, 0, 0, 0, 0, 0, 0, "R7 fence off", 2'b00);
  endtask

  task automatic t_intr_R8();
    access(1, 64'd16, 0, 0, 0, 0, 0, 1, 1, 0, "R8 interrupt seq", 2'b00);
  endtask

  task automatic t_asce_R9();
    access(1, 64'd4100, 0, 0, 0, 0, 0, 1, 0, 1, "R9 asce unavailable", 2'b00);
  endtask

  task automatic t_prio_R10();
    access(1, 64'd8, 1, 1, 1, 0, 1, 1, 0, 0, "R10 all three", 2'b11);
    access(1, 64'd8, 0, 1, 0, 1, 1, 1, 0, 0, "R10 page over low", 2'b10);
    access(1, 64'd8, 1, 0, 0, 0, 1, 1, 0, 0, "R10 ale over low", 2'b11);
  endtask

  task automatic t_back_to_back_R11();
    access(1, 64'd4, 0, 0, 0, 0, 0, 1, 0, 0, "R11 exception", 2'b01);
    access(1, 64'd4, 0, 0, 0, 0, 0, 0, 0, 0, "R11 next clean", 2'b00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset_R1();
    @(negedge clk); rst_n = 1;
    t_idle_R2();
    t_fetch_R3();
    t_ale_R4();
    t_page_R5();
    t_low_R6();
    t_lap_off_R7();
    t_intr_R8();
    t_asce_R9();
    t_prio_R10();
    t_back_to_back_R11();
    t_idle_R2();
    finish_run();
  end
endmodule